// File: doc/BRIEF.md
# Dibit-to-Nibble Bridge for a 10/100 Ethernet Datapath

This block sits between a two-bit reduced media-independent interface and a four-bit nibble interface. Both directions run from one shared reference clock of 50 MHz.

On the transmit side, it collects two-bit symbols ("dibits") while the transmit enable is high. It packs each pair of dibits into a nibble and flags that nibble valid for one clock. On the receive side, it takes a nibble marked valid and sends it out as two dibits, low half first, with a carrier/data-valid flag.

A speed input selects the rate. At 100 Mb/s a dibit moves on every clock. At 10 Mb/s a dibit is sampled, or held on the output, once every ten clocks. A pacing counter keeps that ten-clock cadence. The counter restarts whenever its direction is idle, so the first dibit of a frame is always handled on the first clock it is offered. The speed input is expected to stay constant while a frame is in flight.

Top module: `rmii_nibble_bridge`

## Requirements
- R1: After reset, `tx_nib_vld` is 0, `crs_dv` is 0 and `rxd` is 2'b00.
- R2: With `speed_100`=1, `txd` is sampled on every clock where `tx_en` is high. The first dibit of each pair becomes bits [1:0] of the nibble and the second becomes bits [3:2]. `tx_nib_vld` is high for exactly one clock, in the cycle after the edge that sampled the second dibit, and `tx_nib` holds the packed value in that cycle.
- R3: With `speed_100`=0, `tx_en` and `txd` are sampled once every 10 clocks. The first sample is taken on the first clock where `tx_en` is seen high after idle. Packing and the one-clock valid pulse follow R2.
- R4: If `tx_en` is seen low at a sample point while only one dibit of a nibble has been collected, that dibit is dropped and no valid nibble is produced. The next frame packs from a fresh nibble boundary.
- R5: While `tx_en` is low, `txd` has no effect and `tx_nib_vld` stays 0.
- R6: With `speed_100`=1, a nibble presented with `rx_nib_vld`=1 at a dibit boundary is accepted. `rxd` shows nibble bits [1:0] in the following clock and bits [3:2] in the clock after that, with `crs_dv`=1 in both. The next nibble is taken two clocks after the previous one.
- R7: With `speed_100`=0, each receive dibit is held on `rxd` for 10 clocks, with `crs_dv`=1. The next nibble is accepted 20 clocks after the previous one.
- R8: When no valid nibble is offered at the boundary after the last dibit, `crs_dv` falls one dibit period after that dibit began, and `rxd` returns to 2'b00. While `crs_dv` is low, `rxd` stays 2'b00. `rx_nib` is ignored whenever `rx_nib_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock for both directions |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = 100 Mb/s (every clock), 0 = 10 Mb/s (every tenth clock) |
| tx_en | input | 1 | Transmit enable on the dibit side |
| txd | input | 2 | Transmit dibit |
| tx_nib | output | 4 | Packed transmit nibble |
| tx_nib_vld | output | 1 | One-clock valid pulse for `tx_nib` |
| rx_nib | input | 4 | Receive nibble to serialise |
| rx_nib_vld | input | 1 | Valid flag for `rx_nib` |
| rxd | output | 2 | Receive dibit |
| crs_dv | output | 1 | High while receive dibits are being driven |

## Verification
Each result has a fixed due cycle:
- A transmit nibble is due in the cycle right after the rising edge that sampled its second dibit.
- A receive dibit is due right after the edge that loaded it.
- At 10 Mb/s, each later dibit is due ten edges after the one before it.
- The fall of `crs_dv` is due on the first sample edge after the last dibit's period.

The bench changes inputs and samples outputs only on falling edges. It counts rising edges from the first offered dibit or nibble, and it checks the outputs in every cycle of a frame. This way, a missing pulse, an extra pulse and an early or late pulse are all reported in the exact cycle where they occur.

// File: rtl/rmii_bridge_pkg.sv
package rmii_bridge_pkg;
   localparam int DIBIT_W = 2;
   localparam int NIB_W   = 2 * DIBIT_W;
   typedef logic [DIBIT_W-1:0] dibit_t;
   typedef logic [NIB_W-1:0]   nibble_t;
endpackage

// File: rtl/rmii_pace_gen.sv
// Produces the dibit-rate strobe: every clock when fast, else every DIV clocks.
// Held at phase zero while the owning direction is idle.
module rmii_pace_gen #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast,
   input  logic hold,
   output logic strobe
);
   initial begin
      if (DIV < 1) $error("rmii_pace_gen: DIV must be at least 1");
   end

   generate
      if (DIV > 1) begin : g_cnt
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (hold)        cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign strobe = fast | (cnt == '0);
      end else begin : g_flat
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, fast, hold};
         assign strobe    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/rmii_tx_pack.sv
module rmii_tx_pack
   import rmii_bridge_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    strobe,
   input  logic    tx_en,
   input  dibit_t  txd,
   output nibble_t nib,
   output logic    nib_vld,
   output logic    busy
);
   logic   half;
   dibit_t lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half    <= 1'b0;
         lo_q    <= '0;
         nib     <= '0;
         nib_vld <= 1'b0;
         busy    <= 1'b0;
      end else begin
         nib_vld <= 1'b0;
         if (strobe) begin
            busy <= tx_en;
            if (tx_en) begin
               if (!half) begin
                  lo_q <= txd;
                  half <= 1'b1;
               end else begin
                  nib     <= {txd, lo_q};
                  nib_vld <= 1'b1;
                  half    <= 1'b0;
               end
            end else begin
               half <= 1'b0;   // drop a lone dibit
            end
         end
      end
   end
endmodule

// File: rtl/rmii_rx_unpack.sv
module rmii_rx_unpack
   import rmii_bridge_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    strobe,
   input  nibble_t nib_in,
   input  logic    nib_vld,
   output dibit_t  rxd,
   output logic    crs_dv
);
   logic   half;
   dibit_t hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half   <= 1'b0;
         hi_q   <= '0;
         rxd    <= '0;
         crs_dv <= 1'b0;
      end else if (strobe) begin
         if (half) begin
            rxd  <= hi_q;
            half <= 1'b0;
         end else if (nib_vld) begin
            rxd    <= nib_in[DIBIT_W-1:0];
            hi_q   <= nib_in[NIB_W-1:DIBIT_W];
            half   <= 1'b1;
            crs_dv <= 1'b1;
         end else begin
            rxd    <= '0;
            crs_dv <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rmii_nibble_bridge.sv
module rmii_nibble_bridge
   import rmii_bridge_pkg::*;
#(
   parameter int SLOW_DIV = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             speed_100,
   input  logic             tx_en,
   input  logic [DIBIT_W-1:0] txd,
   output logic [NIB_W-1:0]   tx_nib,
   output logic             tx_nib_vld,
   input  logic [NIB_W-1:0]   rx_nib,
   input  logic             rx_nib_vld,
   output logic [DIBIT_W-1:0] rxd,
   output logic             crs_dv
);
   logic tx_stb, rx_stb, tx_busy;
   logic tx_hold, rx_hold;

   assign tx_hold = ~tx_en & ~tx_busy;
   assign rx_hold = ~rx_nib_vld & ~crs_dv;

   rmii_pace_gen #(.DIV(SLOW_DIV)) u_tx_pace (
      .clk(clk), .rst_n(rst_n), .fast(speed_100), .hold(tx_hold), .strobe(tx_stb)
   );

   rmii_pace_gen #(.DIV(SLOW_DIV)) u_rx_pace (
      .clk(clk), .rst_n(rst_n), .fast(speed_100), .hold(rx_hold), .strobe(rx_stb)
   );

   rmii_tx_pack u_tx (
      .clk(clk), .rst_n(rst_n), .strobe(tx_stb), .tx_en(tx_en), .txd(txd),
      .nib(tx_nib), .nib_vld(tx_nib_vld), .busy(tx_busy)
   );

   rmii_rx_unpack u_rx (
      .clk(clk), .rst_n(rst_n), .strobe(rx_stb), .nib_in(rx_nib),
      .nib_vld(rx_nib_vld), .rxd(rxd), .crs_dv(crs_dv)
   );
endmodule

// File: rtl/rmii_bridge_chk.sv
module rmii_bridge_chk
   import rmii_bridge_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               tx_en,
   input logic [DIBIT_W-1:0] txd,
   input logic [NIB_W-1:0]   tx_nib,
   input logic               tx_nib_vld,
   input logic [NIB_W-1:0]   rx_nib,
   input logic               rx_nib_vld,
   input logic [DIBIT_W-1:0] rxd,
   input logic               crs_dv
);
   // R2
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_nib_vld |=> !tx_nib_vld);

   // R5
   vld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_nib_vld) |-> $past(tx_en));

   // R2
   hi_dibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_nib_vld) |-> tx_nib[NIB_W-1:DIBIT_W] == $past(txd));

   // R6
   crs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crs_dv) |-> $past(rx_nib_vld) && rxd == $past(rx_nib[DIBIT_W-1:0]));

   // R8
   idle_rxd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !crs_dv |-> rxd == '0);
endmodule

bind rmii_nibble_bridge rmii_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .tx_nib(tx_nib),
   .tx_nib_vld(tx_nib_vld), .rx_nib(rx_nib), .rx_nib_vld(rx_nib_vld),
   .rxd(rxd), .crs_dv(crs_dv)
);

// File: tb/sim_rmii_nibble_bridge.sv
`timescale 1ns/1ps
module sim_rmii_nibble_bridge;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       speed_100 = 1'b1;
   logic       tx_en = 1'b0;
   logic [1:0] txd = 2'b00;
   logic [3:0] tx_nib;
   logic       tx_nib_vld;
   logic [3:0] rx_nib = 4'h0;
   logic       rx_nib_vld = 1'b0;
   logic [1:0] rxd;
   logic       crs_dv;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rmii_nibble_bridge u0 (
      .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .tx_en(tx_en), .txd(txd),
      .tx_nib(tx_nib), .tx_nib_vld(tx_nib_vld), .rx_nib(rx_nib),
      .rx_nib_vld(rx_nib_vld), .rxd(rxd), .crs_dv(crs_dv)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] dib(input int seed, input int k);
      return 2'((seed + k * 3 + k / 4) & 3);
   endfunction

   function automatic logic [3:0] nibv(input int seed, input int i);
      return 4'((seed * 5 + i * 7 + 3) & 15);
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   // R1
   task automatic t_reset;
      chk("R1 vld", {7'd0, tx_nib_vld}, 8'd0);
      chk("R1 crs_dv", {7'd0, crs_dv}, 8'd0);
      chk("R1 rxd", {6'd0, rxd}, 8'd0);
   endtask

   // R2 / R3 / R4 / R5
   task automatic t_tx(input logic slow, input int n, input int seed);
      int per = slow ? 10 : 1;
      string tag = slow ? "R3" : "R2";
      speed_100 = ~slow;
      for (int k = 0; k < n; k++) begin
         tx_en = 1'b1;
         txd   = dib(seed, k);
         for (int c = 0; c < per; c++) begin
            @(posedge clk); @(negedge clk);
            if ((k % 2 == 1) && c == 0) begin
               chk(tag, {7'd0, tx_nib_vld}, 8'd1);
               chk(tag, {4'd0, tx_nib}, {4'd0, dib(seed, k), dib(seed, k - 1)});
            end else begin
               chk(tag, {7'd0, tx_nib_vld}, 8'd0);
            end
         end
      end
      tx_en = 1'b0;
      for (int c = 0; c < 2 * per + 2; c++) begin
         txd = 2'(c);
         @(posedge clk); @(negedge clk);
         chk((n % 2 == 1) ? "R4" : "R5", {7'd0, tx_nib_vld}, 8'd0);
      end
      idle(12);
   endtask

   // R6 / R7 / R8
   task automatic t_rx(input logic slow, input int n, input int seed);
      int per = slow ? 10 : 1;
      string tag = slow ? "R7" : "R6";
      speed_100  = ~slow;
      rx_nib_vld = 1'b1;
      rx_nib     = nibv(seed, 0);
      for (int i = 0; i < n; i++) begin
         for (int j = 0; j < 2 * per; j++) begin
            @(posedge clk); @(negedge clk);
            chk(tag, {7'd0, crs_dv}, 8'd1);
            chk(tag, {6'd0, rxd}, {6'd0, (j < per) ? nibv(seed, i)[1:0] : nibv(seed, i)[3:2]});
         end
         if (i < n - 1) rx_nib = nibv(seed, i + 1);
         else begin
            rx_nib_vld = 1'b0;
            rx_nib     = 4'hF;
         end
      end
      @(posedge clk); @(negedge clk);
      chk("R8 end", {7'd0, crs_dv}, 8'd0);
      chk("R8 end", {6'd0, rxd}, 8'd0);
      for (int c = 0; c < 6; c++) begin
         rx_nib = 4'(c * 5 + 1);
         @(posedge clk); @(negedge clk);
         chk("R8 ignore", {5'd0, crs_dv, rxd}, 8'd0);
      end
      idle(12);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      idle(2);
      t_tx(1'b0, 8, 1);
      t_tx(1'b0, 5, 2);   // odd: last dibit dropped
      t_tx(1'b0, 4, 3);   // fresh boundary after drop
      t_tx(1'b1, 6, 4);
      t_tx(1'b1, 3, 5);
      t_tx(1'b1, 2, 6);
      t_rx(1'b0, 6, 1);
      t_rx(1'b0, 1, 2);
      t_rx(1'b1, 3, 3);
      t_rx(1'b0, 4, 4);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule